// File: doc/BRIEF.md
# Miss-Handling Entry with Primary and Deferred Requester Lists

This block is a single miss-status entry of a non-blocking cache. Once a miss is allocated it remembers the line address, the access size, the secure bit, an order stamp and a ready time. It also keeps every requester waiting on that line. Requesters sit in one of two bounded lists. The primary list is answered by the fetch that is already outstanding. The deferred list holds requesters that must wait for a second fetch, issued after the first one completes.

The owning cache controller drives one operation per cycle on `op`: allocate, add a requester, mark the fetch as issued, apply a snoop outcome, apply a fill, promote the deferred list, retire the head requester, or release the entry. On each add, the entry decides which list the requester joins. It keeps the in-service, ownership-pending, lost-line and downgraded state that drives that choice. When the line has been lost, it rewrites upgrade-type commands into their full-fetch or failing forms. Snoop decisions are made elsewhere and arrive only as two flag inputs. Both lists are circular buffers. Promotion flips a select bit that says which buffer is primary.

Top module: `miss_entry`

## Requirements
- R1: After reset, no entry is valid, both list counts are zero, all state flags are clear, and `stall_o` and `done_o` are low.
- R2: `op`=1 (allocate), when no entry is valid and both lists are empty, records the address, size, secure bit, forward and no-response marks, order (`t_ord`) and ready time (`t_rdy`). It places one requester with command `t_cmd` in the primary list, marked pending. That requester is tagged prefetch when `t_cmd`=7 and CPU otherwise. In-service, ownership-pending and both post flags clear. An allocate while valid changes nothing.
- R3: Command codes are 0 read, 1 read-exclusive, 2 upgrade, 3 SC-upgrade, 4 store-conditional, 5 SC-upgrade-fail, 6 store-conditional-fail and 7 prefetch. A requester stored with code 1 to 6 sets its list's needs-exclusive flag (`p_needex_o` / `d_needex_o`). Codes 2 to 4 mark the list as holding upgrades.
- R4: `op`=2 (add) sends the requester to the deferred list when the entry is in service and at least one of these holds: the deferred list is non-empty, post-invalidate is set, or the command needs exclusive while ownership-pending is clear, post-downgrade is set or the entry is a forward. Otherwise it joins the primary list.
- R5: A requester that joins the primary list is marked pending only when the entry is not yet in service. A deferred requester is always marked pending.
- R6: A requester deferred while post-invalidate is set is stored with its command rewritten: 2 becomes 1, 3 becomes 5, 4 becomes 6. Other codes are stored unchanged.
- R7: `op`=3 (issue), on a valid entry not in service, behaves in one of two ways. On a forward entry with no response, it removes the primary head and pulses `done_o` in the next cycle. Otherwise it sets in-service and sets ownership-pending to (primary needs-exclusive) OR (NOT `rsp_shared` AND `rsp_inhibit`). It also clears both post flags and clears the pending mark of every primary requester.
- R8: `op`=4 (snoop) on a valid entry depends on in-service. In service, `s_inv` sets post-invalidate and rewrites the deferred list's upgrade commands as in R6, and `s_dg` sets post-downgrade. Not in service, `s_inv` rewrites both lists and leaves the flags unchanged.
- R9: `op`=6 (promote) acts only when the primary list is empty and the deferred list is not. The lists exchange roles, and the flags of the list that becomes deferred reset. The order becomes the new head's order and the ready time becomes max(`now`, head ready time). In-service clears.
- R10: `op`=5 (fill) with `fill_shared` low, both post flags clear and deferred needs-exclusive set appends all deferred requesters to the primary list in order, with pending cleared. It then sets primary needs-exclusive and empties the deferred list with its flags reset.
- R11: `op`=7 (release) frees the entry only when both lists are empty. It clears in-service and all flags. Otherwise it changes nothing.
- R12: An add to a list holding 8 requesters, or a fill merge whose combined count would exceed 8, changes no state and raises `stall_o` for one cycle in the next cycle.
- R13: `op`=8 (retire) removes the primary head. Primary requesters leave in the order they joined, and the head's order stamp and ready time appear on `hd_ord_o` and `hd_rdy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code for this cycle (0 idle) |
| a_addr | input | AW (32) | Line address on allocate |
| a_size | input | SW (7) | Access size on allocate |
| a_secure | input | 1 | Secure bit on allocate |
| a_fwd | input | 1 | Entry is a forward on allocate |
| a_noresp | input | 1 | Forward expects no response |
| t_cmd | input | 3 | Requester command code |
| t_ord | input | OW (16) | Requester order stamp |
| t_rdy | input | TW (32) | Requester ready time |
| now | input | TW (32) | Current time, used by promote |
| rsp_shared | input | 1 | Issue outcome: response will be shared |
| rsp_inhibit | input | 1 | Issue outcome: memory inhibited |
| s_inv | input | 1 | Snoop outcome: invalidating |
| s_dg | input | 1 | Snoop outcome: downgrading |
| fill_shared | input | 1 | Fill arrived shared |
| valid_o | output | 1 | Entry allocated |
| addr_o | output | AW (32) | Recorded address |
| size_o | output | SW (7) | Recorded size |
| secure_o | output | 1 | Recorded secure bit |
| ord_o | output | OW (16) | Entry order stamp |
| rdy_o | output | TW (32) | Entry ready time |
| in_service_o | output | 1 | Fetch issued |
| pend_dirty_o | output | 1 | Ownership pending |
| post_inv_o | output | 1 | Line will be lost after the fill |
| post_dg_o | output | 1 | Line will be downgraded after the fill |
| p_cnt_o | output | CW (4) | Primary list count |
| d_cnt_o | output | CW (4) | Deferred list count |
| p_needex_o | output | 1 | Primary list needs exclusive |
| d_needex_o | output | 1 | Deferred list needs exclusive |
| hd_cmd_o | output | 3 | Primary head command |
| hd_ord_o | output | OW (16) | Primary head order stamp |
| hd_rdy_o | output | TW (32) | Primary head ready time |
| hd_pend_o | output | 1 | Primary head pending mark |
| hd_pf_o | output | 1 | Primary head tagged prefetch |
| dh_cmd_o | output | 3 | Deferred head command |
| stall_o | output | 1 | Previous operation refused for lack of room |
| done_o | output | 1 | Forward without response finished |

## Verification
A wrong list choice or a wrong select bit shows in `p_cnt_o` and `d_cnt_o` in the cycle after the add or promote that caused it. A missed command rewrite shows on `dh_cmd_o` or `hd_cmd_o` as soon as the affected requester reaches the head of its list, which may take several retires. A wrong ownership-pending or post flag appears directly on its output after the edge. The same fault can also surface later, as a wrong list choice for the next exclusive requester. The reference model compares every output on every cycle, so a divergence is reported in the first cycle it becomes visible.

// File: rtl/miss_entry.sv
module miss_entry #(
  parameter int AW    = 32,
  parameter int SW    = 7,
  parameter int OW    = 16,
  parameter int TW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [AW-1:0] a_addr,
  input  logic [SW-1:0] a_size,
  input  logic          a_secure,
  input  logic          a_fwd,
  input  logic          a_noresp,
  input  logic [2:0]    t_cmd,
  input  logic [OW-1:0] t_ord,
  input  logic [TW-1:0] t_rdy,
  input  logic [TW-1:0] now,
  input  logic          rsp_shared,
  input  logic          rsp_inhibit,
  input  logic          s_inv,
  input  logic          s_dg,
  input  logic          fill_shared,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [SW-1:0] size_o,
  output logic          secure_o,
  output logic [OW-1:0] ord_o,
  output logic [TW-1:0] rdy_o,
  output logic          in_service_o,
  output logic          pend_dirty_o,
  output logic          post_inv_o,
  output logic          post_dg_o,
  output logic [CW-1:0] p_cnt_o,
  output logic [CW-1:0] d_cnt_o,
  output logic          p_needex_o,
  output logic          d_needex_o,
  output logic [2:0]    hd_cmd_o,
  output logic [OW-1:0] hd_ord_o,
  output logic [TW-1:0] hd_rdy_o,
  output logic          hd_pend_o,
  output logic          hd_pf_o,
  output logic [2:0]    dh_cmd_o,
  output logic          stall_o,
  output logic          done_o
);

  localparam logic [3:0] OP_ALLOC   = 4'd1;
  localparam logic [3:0] OP_ADD     = 4'd2;
  localparam logic [3:0] OP_ISSUE   = 4'd3;
  localparam logic [3:0] OP_SNOOP   = 4'd4;
  localparam logic [3:0] OP_FILL    = 4'd5;
  localparam logic [3:0] OP_PROMOTE = 4'd6;
  localparam logic [3:0] OP_FREE    = 4'd7;
  localparam logic [3:0] OP_RETIRE  = 4'd8;

  function automatic logic f_nx(input logic [2:0] c);
    return (c != 3'd0) && (c != 3'd7);
  endfunction

  function automatic logic f_up(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  function automatic logic [2:0] f_rw(input logic [2:0] c);
    case (c)
      3'd2:    return 3'd1;
      3'd3:    return 3'd5;
      3'd4:    return 3'd6;
      default: return c;
    endcase
  endfunction

  // two physical buffers; sel names the one acting as primary
  logic [2:0]    bcmd  [2][DEPTH];
  logic [OW-1:0] bord  [2][DEPTH];
  logic [TW-1:0] brdy  [2][DEPTH];
  logic          bpf   [2][DEPTH];
  logic          bpend [2][DEPTH];
  logic [IW-1:0] hd [2];
  logic [CW-1:0] cn [2];
  logic          nx [2];
  logic          up [2];
  logic          sel;

  logic          valid, insvc, pdirty, pinv, pdg, fwd_q, nores_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic          sec_q;
  logic [OW-1:0] ord_q;
  logic [TW-1:0] rdy_q;
  logic          stall_q, done_q;

  logic          pl, dl, defer, tl, merge_ok;
  logic [2:0]    wcmd;
  logic [IW-1:0] wslot;
  logic [CW:0]   msum;
  logic [TW-1:0] dh_rdy;

  assign pl       = sel;
  assign dl       = ~sel;
  assign defer    = insvc && ((cn[dl] != '0) || pinv ||
                    (f_nx(t_cmd) && (!pdirty || pdg || fwd_q)));
  assign tl       = defer ? dl : pl;
  assign wcmd     = (defer && pinv) ? f_rw(t_cmd) : t_cmd;
  assign wslot    = hd[tl] + cn[tl][IW-1:0];
  assign msum     = {1'b0, cn[pl]} + {1'b0, cn[dl]};
  assign merge_ok = valid && !fill_shared && !pinv && !pdg && nx[dl];
  assign dh_rdy   = brdy[dl][hd[dl]];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      insvc   <= 1'b0;
      pdirty  <= 1'b0;
      pinv    <= 1'b0;
      pdg     <= 1'b0;
      fwd_q   <= 1'b0;
      nores_q <= 1'b0;
      sel     <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      sec_q   <= 1'b0;
      ord_q   <= '0;
      rdy_q   <= '0;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        hd[b] <= '0;
        cn[b] <= '0;
        nx[b] <= 1'b0;
        up[b] <= 1'b0;
      end
    end else begin
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      case (op)
        OP_ALLOC: if (!valid && cn[pl] == '0 && cn[dl] == '0) begin
          valid   <= 1'b1;
          addr_q  <= a_addr;
          size_q  <= a_size;
          sec_q   <= a_secure;
          fwd_q   <= a_fwd;
          nores_q <= a_noresp;
          ord_q   <= t_ord;
          rdy_q   <= t_rdy;
          insvc   <= 1'b0;
          pdirty  <= 1'b0;
          pinv    <= 1'b0;
          pdg     <= 1'b0;
          bcmd[pl][hd[pl]]  <= t_cmd;
          bord[pl][hd[pl]]  <= t_ord;
          brdy[pl][hd[pl]]  <= t_rdy;
          bpf[pl][hd[pl]]   <= (t_cmd == 3'd7);
          bpend[pl][hd[pl]] <= 1'b1;
          cn[pl] <= CW'(1);
          nx[pl] <= f_nx(t_cmd);
          up[pl] <= f_up(t_cmd);
          nx[dl] <= 1'b0;
          up[dl] <= 1'b0;
        end
        OP_ADD: if (valid) begin
          if (cn[tl] == CW'(DEPTH)) begin
            stall_q <= 1'b1;
          end else begin
            bcmd[tl][wslot]  <= wcmd;
            bord[tl][wslot]  <= t_ord;
            brdy[tl][wslot]  <= t_rdy;
            bpf[tl][wslot]   <= 1'b0;
            bpend[tl][wslot] <= defer | ~insvc;
            cn[tl] <= cn[tl] + CW'(1);
            if (f_nx(wcmd)) nx[tl] <= 1'b1;
            if (f_up(wcmd)) up[tl] <= 1'b1;
          end
        end
        OP_ISSUE: if (valid && !insvc) begin
          if (fwd_q && nores_q) begin
            if (cn[pl] != '0) begin
              hd[pl] <= hd[pl] + IW'(1);
              cn[pl] <= cn[pl] - CW'(1);
            end
            done_q <= 1'b1;
          end else begin
            insvc  <= 1'b1;
            pdirty <= nx[pl] | (~rsp_shared & rsp_inhibit);
            pinv   <= 1'b0;
            pdg    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) bpend[pl][i] <= 1'b0;
          end
        end
        OP_SNOOP: if (valid) begin
          if (insvc) begin
            if (s_inv) begin
              pinv   <= 1'b1;
              up[dl] <= 1'b0;
              for (int i = 0; i < DEPTH; i++) bcmd[dl][i] <= f_rw(bcmd[dl][i]);
            end
            if (s_dg) pdg <= 1'b1;
          end else if (s_inv) begin
            up[0] <= 1'b0;
            up[1] <= 1'b0;
            for (int b = 0; b < 2; b++)
              for (int i = 0; i < DEPTH; i++) bcmd[b][i] <= f_rw(bcmd[b][i]);
          end
        end
        OP_FILL: if (merge_ok) begin
          if (msum > (CW+1)'(DEPTH)) begin
            stall_q <= 1'b1;
          end else begin
            for (int i = 0; i < DEPTH; i++) begin
              if (i < int'(cn[dl])) begin
                bcmd[pl][hd[pl] + cn[pl][IW-1:0] + IW'(i)]  <= bcmd[dl][hd[dl] + IW'(i)];
                bord[pl][hd[pl] + cn[pl][IW-1:0] + IW'(i)]  <= bord[dl][hd[dl] + IW'(i)];
                brdy[pl][hd[pl] + cn[pl][IW-1:0] + IW'(i)]  <= brdy[dl][hd[dl] + IW'(i)];
                bpf[pl][hd[pl] + cn[pl][IW-1:0] + IW'(i)]   <= bpf[dl][hd[dl] + IW'(i)];
                bpend[pl][hd[pl] + cn[pl][IW-1:0] + IW'(i)] <= 1'b0;
              end
            end
            cn[pl] <= msum[CW-1:0];
            cn[dl] <= '0;
            nx[pl] <= 1'b1;
            up[pl] <= up[pl] | up[dl];
            nx[dl] <= 1'b0;
            up[dl] <= 1'b0;
          end
        end
        OP_PROMOTE: if (valid && cn[pl] == '0 && cn[dl] != '0) begin
          sel    <= ~sel;
          nx[pl] <= 1'b0;
          up[pl] <= 1'b0;
          ord_q  <= bord[dl][hd[dl]];
          rdy_q  <= (now > dh_rdy) ? now : dh_rdy;
          insvc  <= 1'b0;
        end
        OP_FREE: if (valid && cn[pl] == '0 && cn[dl] == '0) begin
          valid  <= 1'b0;
          insvc  <= 1'b0;
          pdirty <= 1'b0;
          pinv   <= 1'b0;
          pdg    <= 1'b0;
          for (int b = 0; b < 2; b++) begin
            nx[b] <= 1'b0;
            up[b] <= 1'b0;
          end
        end
        OP_RETIRE: if (valid && cn[pl] != '0) begin
          hd[pl] <= hd[pl] + IW'(1);
          cn[pl] <= cn[pl] - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign valid_o      = valid;
  assign addr_o       = addr_q;
  assign size_o       = size_q;
  assign secure_o     = sec_q;
  assign ord_o        = ord_q;
  assign rdy_o        = rdy_q;
  assign in_service_o = insvc;
  assign pend_dirty_o = pdirty;
  assign post_inv_o   = pinv;
  assign post_dg_o    = pdg;
  assign p_cnt_o      = cn[pl];
  assign d_cnt_o      = cn[dl];
  assign p_needex_o   = nx[pl];
  assign d_needex_o   = nx[dl];
  assign hd_cmd_o     = bcmd[pl][hd[pl]];
  assign hd_ord_o     = bord[pl][hd[pl]];
  assign hd_rdy_o     = brdy[pl][hd[pl]];
  assign hd_pend_o    = bpend[pl][hd[pl]];
  assign hd_pf_o      = bpf[pl][hd[pl]];
  assign dh_cmd_o     = bcmd[dl][hd[dl]];
  assign stall_o      = stall_q;
  assign done_o       = done_q;

endmodule

// File: rtl/miss_entry_chk.sv
module miss_entry_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op,
  input logic          valid,
  input logic          insvc,
  input logic          fwd,
  input logic          noresp,
  input logic [CW-1:0] p_cnt,
  input logic [CW-1:0] d_cnt,
  input logic          stall,
  input logic          done
);

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (p_cnt <= CW'(DEPTH)) && (d_cnt <= CW'(DEPTH)));

  a_r2_alloc_one_target: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 && !valid && p_cnt == '0 && d_cnt == '0) |=>
    (valid && p_cnt == CW'(1) && !insvc));

  a_r7_issue_sets_service: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3 && valid && !insvc && !(fwd && noresp)) |=> insvc);

  a_r7_done_after_issue: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(op) == 4'd3));

  a_r9_promote_refused: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd6 && p_cnt != '0) |=> ($stable(p_cnt) && $stable(d_cnt)));

  a_r11_free_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd7 && p_cnt == '0 && d_cnt == '0) |=> !valid);

  a_r12_stall_keeps_counts: assert property (@(posedge clk) disable iff (rst)
    stall |-> (p_cnt == $past(p_cnt) && d_cnt == $past(d_cnt)));

endmodule

bind miss_entry miss_entry_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op     (op),
  .valid  (valid_o),
  .insvc  (in_service_o),
  .fwd    (fwd_q),
  .noresp (nores_q),
  .p_cnt  (p_cnt_o),
  .d_cnt  (d_cnt_o),
  .stall  (stall_o),
  .done   (done_o)
);

// File: tb/miss_entry_bench.sv
module miss_entry_bench;
  typedef struct packed {
    logic [2:0]  cmd;
    logic        pf;
    logic        pend;
    logic [15:0] ord;
    logic [31:0] rdy;
  } tgt_t;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [3:0]  op = 0;
  logic [31:0] a_addr = 0;
  logic [6:0]  a_size = 0;
  logic        a_secure = 0, a_fwd = 0, a_noresp = 0;
  logic [2:0]  t_cmd = 0;
  logic [15:0] t_ord = 0;
  logic [31:0] t_rdy = 0, now = 0;
  logic        rsp_shared = 0, rsp_inhibit = 0, s_inv = 0, s_dg = 0, fill_shared = 0;

  logic        valid_o, secure_o, in_service_o, pend_dirty_o, post_inv_o, post_dg_o;
  logic [31:0] addr_o, rdy_o, hd_rdy_o;
  logic [6:0]  size_o;
  logic [15:0] ord_o, hd_ord_o;
  logic [3:0]  p_cnt_o, d_cnt_o;
  logic        p_needex_o, d_needex_o, hd_pend_o, hd_pf_o, stall_o, done_o;
  logic [2:0]  hd_cmd_o, dh_cmd_o;

  miss_entry u_miss_entry (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  tgt_t mp[$], md[$];
  logic        mv, mins, mpd, mpi, mpg, mfwd, mnr, pnx, pup, dnx, dup, estall, edone;
  logic [31:0] maddr, mrdy;
  logic [6:0]  msize;
  logic        msec;
  logic [15:0] mord;

  function automatic logic nx_of(input logic [2:0] c); return c != 0 && c != 7; endfunction
  function automatic logic up_of(input logic [2:0] c); return c == 2 || c == 3 || c == 4; endfunction
  function automatic logic [2:0] rw(input logic [2:0] c);
    return c == 2 ? 3'd1 : c == 3 ? 3'd5 : c == 4 ? 3'd6 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mp.delete(); md.delete();
    {mv, mins, mpd, mpi, mpg, mfwd, mnr, pnx, pup, dnx, dup, estall, edone} = '0;
    maddr = 0; mrdy = 0; msize = 0; msec = 0; mord = 0;
  endtask

  task automatic model_apply();
    estall = 0; edone = 0;
    case (op)
      1: if (!mv && mp.size() == 0 && md.size() == 0) begin
        mv = 1; maddr = a_addr; msize = a_size; msec = a_secure; mfwd = a_fwd; mnr = a_noresp;
        mord = t_ord; mrdy = t_rdy; mins = 0; mpd = 0; mpi = 0; mpg = 0;
        mp.push_back('{t_cmd, t_cmd == 7, 1'b1, t_ord, t_rdy});
        pnx = nx_of(t_cmd); pup = up_of(t_cmd); dnx = 0; dup = 0;
      end
      2: if (mv) begin
        bit dfr = mins && (md.size() != 0 || mpi || (nx_of(t_cmd) && (!mpd || mpg || mfwd)));
        logic [2:0] c = (dfr && mpi) ? rw(t_cmd) : t_cmd;
        if (dfr) begin
          if (md.size() == 8) estall = 1;
          else begin
            md.push_back('{c, 1'b0, 1'b1, t_ord, t_rdy});
            if (nx_of(c)) dnx = 1; if (up_of(c)) dup = 1;
          end
        end else begin
          if (mp.size() == 8) estall = 1;
          else begin
            mp.push_back('{c, 1'b0, !mins, t_ord, t_rdy});
            if (nx_of(c)) pnx = 1; if (up_of(c)) pup = 1;
          end
        end
      end
      3: if (mv && !mins) begin
        if (mfwd && mnr) begin
          if (mp.size() != 0) void'(mp.pop_front());
          edone = 1;
        end else begin
          mins = 1; mpd = pnx | (!rsp_shared & rsp_inhibit); mpi = 0; mpg = 0;
          foreach (mp[i]) mp[i].pend = 0;
        end
      end
      4: if (mv) begin
        if (mins) begin
          if (s_inv) begin mpi = 1; dup = 0; foreach (md[i]) md[i].cmd = rw(md[i].cmd); end
          if (s_dg) mpg = 1;
        end else if (s_inv) begin
          pup = 0; dup = 0;
          foreach (mp[i]) mp[i].cmd = rw(mp[i].cmd);
          foreach (md[i]) md[i].cmd = rw(md[i].cmd);
        end
      end
      5: if (mv && !fill_shared && !mpi && !mpg && dnx) begin
        if (mp.size() + md.size() > 8) estall = 1;
        else begin
          foreach (md[i]) begin tgt_t t = md[i]; t.pend = 0; mp.push_back(t); end
          md.delete(); pnx = 1; pup = pup | dup; dnx = 0; dup = 0;
        end
      end
      6: if (mv && mp.size() == 0 && md.size() != 0) begin
        mp = md; md.delete(); pnx = dnx; pup = dup; dnx = 0; dup = 0;
        mord = mp[0].ord; mrdy = (now > mp[0].rdy) ? now : mp[0].rdy; mins = 0;
      end
      7: if (mv && mp.size() == 0 && md.size() == 0) begin
        mv = 0; mins = 0; mpd = 0; mpi = 0; mpg = 0; pnx = 0; pup = 0; dnx = 0; dup = 0;
      end
      8: if (mv && mp.size() != 0) void'(mp.pop_front());
      default: ;
    endcase
  endtask

  task automatic compare();
    chk(valid_o == mv, "R2", "valid", valid_o, mv);
    if (mv) begin
      chk(addr_o == maddr, "R2", "addr", addr_o, maddr);
      chk(size_o == msize, "R2", "size", size_o, msize);
      chk(secure_o == msec, "R2", "secure", secure_o, msec);
      chk(ord_o == mord, "R9", "order", ord_o, mord);
      chk(rdy_o == mrdy, "R9", "ready", rdy_o, mrdy);
    end
    chk(in_service_o == mins, "R7", "in_service", in_service_o, mins);
    chk(pend_dirty_o == mpd, "R7", "pend_dirty", pend_dirty_o, mpd);
    chk(post_inv_o == mpi, "R8", "post_inv", post_inv_o, mpi);
    chk(post_dg_o == mpg, "R8", "post_dg", post_dg_o, mpg);
    chk(p_cnt_o == mp.size(), "R4", "p_cnt", p_cnt_o, mp.size());
    chk(d_cnt_o == md.size(), "R4", "d_cnt", d_cnt_o, md.size());
    chk(p_needex_o == pnx, "R3", "p_needex", p_needex_o, pnx);
    chk(d_needex_o == dnx, "R3", "d_needex", d_needex_o, dnx);
    chk(stall_o == estall, "R12", "stall", stall_o, estall);
    chk(done_o == edone, "R7", "done", done_o, edone);
    if (mp.size() != 0) begin
      chk(hd_cmd_o == mp[0].cmd, "R6", "hd_cmd", hd_cmd_o, mp[0].cmd);
      chk(hd_ord_o == mp[0].ord, "R13", "hd_ord", hd_ord_o, mp[0].ord);
      chk(hd_rdy_o == mp[0].rdy, "R13", "hd_rdy", hd_rdy_o, mp[0].rdy);
      chk(hd_pend_o == mp[0].pend, "R5", "hd_pend", hd_pend_o, mp[0].pend);
      chk(hd_pf_o == mp[0].pf, "R2", "hd_pf", hd_pf_o, mp[0].pf);
    end
    if (md.size() != 0)
      chk(dh_cmd_o == md[0].cmd, "R6", "dh_cmd", dh_cmd_o, md[0].cmd);
  endtask

  task automatic cyc(input logic [3:0] o);
    op = o;
    model_apply();
    @(negedge clk);
    compare();
    op = 0;
  endtask

  task automatic alloc(input logic [2:0] c, input logic [15:0] o, input logic [31:0] r,
                       input logic f, input logic n);
    a_addr = 32'h4000 + {16'd0, o}; a_size = 7'd64; a_secure = o[0];
    a_fwd = f; a_noresp = n; t_cmd = c; t_ord = o; t_rdy = r; cyc(1);
  endtask
  task automatic add(input logic [2:0] c, input logic [15:0] o);
    t_cmd = c; t_ord = o; t_rdy = 32'(o) * 3; cyc(2);
  endtask
  task automatic issue(input logic sh, input logic inh);
    rsp_shared = sh; rsp_inhibit = inh; cyc(3);
  endtask
  task automatic snoop(input logic inv, input logic dg);
    s_inv = inv; s_dg = dg; cyc(4);
  endtask
  task automatic fill(input logic sh); fill_shared = sh; cyc(5); endtask
  task automatic promote(input logic [31:0] t); now = t; cyc(6); endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(!valid_o && p_cnt_o == 0 && d_cnt_o == 0 && !stall_o && !done_o && !in_service_o,
        "R1", "reset state", {valid_o, p_cnt_o, d_cnt_o}, 0);
    compare();

    // primary and deferred placement, promotion
    alloc(0, 10, 100, 0, 0);
    add(0, 11);                       // before service: primary, pending (R5)
    issue(1, 0);                      // shared, no exclusive: not pending-dirty
    add(1, 12);                       // exclusive while not pending-dirty: deferred (R4)
    add(0, 13);                       // deferred list non-empty: deferred (R4)
    cyc(8); cyc(8);
    promote(5);
    chk(p_cnt_o == 2 && d_cnt_o == 0 && ord_o == 12, "R9", "promote swap",
        {p_cnt_o, ord_o}, {4'd2, 16'd12});
    promote(5);                       // refused: primary not empty

    // ownership pending, downgrade, invalidate rewrites
    issue(1, 0);                      // primary needs exclusive -> pending-dirty
    add(1, 14);                       // joins primary, not pending
    snoop(0, 1);
    add(1, 15);                       // downgrade set: deferred
    snoop(1, 0);
    add(2, 16); add(3, 17); add(4, 18); add(0, 19);
    fill(0);                          // post flags set: no merge
    repeat (3) cyc(8);
    cyc(7);                           // refused: lists not empty
    chk(valid_o == 1, "R11", "free refused", valid_o, 1);
    promote(200);
    repeat (5) cyc(8);
    cyc(7);
    chk(valid_o == 0, "R11", "free accepted", valid_o, 0);

    // exclusive fill merges deferred requesters
    alloc(0, 30, 7, 0, 0);
    issue(1, 0);
    add(1, 31); add(2, 32);
    fill(0);
    chk(p_cnt_o == 3 && d_cnt_o == 0 && p_needex_o, "R10", "merge",
        {p_cnt_o, d_cnt_o}, {4'd3, 4'd0});
    repeat (3) cyc(8);
    cyc(7);

    // full primary list stalls
    alloc(7, 40, 9, 0, 0);            // prefetch tag (R2)
    for (int i = 0; i < 8; i++) add(0, 16'(41 + i));
    chk(stall_o == 1 && p_cnt_o == 8, "R12", "full add", stall_o, 1);
    repeat (8) cyc(8);
    cyc(7);

    // forward without response
    alloc(0, 50, 1, 1, 1);
    issue(0, 1);
    chk(done_o == 1 && p_cnt_o == 0, "R7", "forward done", done_o, 1);
    cyc(7);

    // invalidating snoop before service rewrites primary
    alloc(2, 60, 1, 0, 0);
    alloc(0, 61, 1, 0, 0);            // ignored while valid
    snoop(1, 0);
    chk(hd_cmd_o == 3'd1, "R8", "rewrite before issue", hd_cmd_o, 1);
    cyc(8); cyc(7);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 11);
      a_addr = $urandom; a_size = 7'($urandom); a_secure = 1'($urandom);
      a_fwd = ($urandom_range(0, 5) == 0); a_noresp = ($urandom_range(0, 2) == 0);
      t_cmd = 3'($urandom_range(0, 6)); t_ord = 16'($urandom); t_rdy = $urandom_range(0, 1000);
      now = $urandom_range(0, 1000);
      rsp_shared = 1'($urandom); rsp_inhibit = 1'($urandom);
      s_inv = 1'($urandom); s_dg = 1'($urandom); fill_shared = ($urandom_range(0, 2) == 0);
      case (r)
        0: cyc(1);
        1, 2, 3: cyc(2);
        4: cyc(3);
        5: cyc(4);
        6: cyc(5);
        7: cyc(6);
        8: cyc(7);
        9, 10: cyc(8);
        default: cyc(0);
      endcase
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule